// File: doc/BRIEF.md
# Three-Channel Center-Aligned PWM with Half-Step Dithering

The block turns three 10-bit magnitude words into three center-aligned PWM lines. All channels share one triangular 8-bit counter that climbs from 0 to its peak of 255 and falls back, one step per system tick. A channel stays high while its counter value is no larger than the upper eight bits of its word. The two low bits lengthen that high interval in half-tick steps, so the effective resolution is 10 bits without a longer counter.

The block runs on a fast clock at twice the system rate. An enable input, high on every other fast cycle, marks the system ticks. The fast cycle between two ticks supplies the half-tick grain. Words are captured into per-channel shadow registers only as the counter returns to zero, so a period is never cut mid-way. A frame output marks the tick during which the counter sits at zero. Outputs are decoded from registers only. Sign handling, dead time and the drive stage are outside this block.

Top module: `tri_dither_pwm`

## Requirements
- R1: With `tick_i` high on every second clock, the counter runs 0,1,...,255,254,...,1 and repeats, so a period lasts 510 ticks (1020 clocks). `frame_o` is high for exactly the 2 clocks of the tick at counter 0 and rises again 1020 clocks later.
- R2: Within one period, channel c is high for min(word+2, 1020) clocks, where word is the 10-bit value of `duty_i[c]` in force for that period. Each channel depends only on its own word.
- R3: Let M be bits [9:2] of the word. Ignoring the low bits, a channel is high during every tick whose counter value is at most M and low during every other tick.
- R4: Let L be bits [1:0] of the word. The high time grows by L half-ticks (clocks). ceil(L/2) of them follow the rising-side tick at counter M, taken from the tick at counter M+1, first half first. floor(L/2) of them precede the falling-side tick at counter M, taken from the second half of the tick at counter M+1.
- R5: M = 255 keeps a channel high for the whole period. M = 254 saturates: L = 1 leaves exactly one low clock (the second half of the peak tick), and L of 2 or 3 gives a fully high period.
- R6: A word is captured only on the tick that moves the counter from 1 to 0. A change on `duty_i` at any other time has no effect on the current period.
- R7: A word of 0 still produces one 2-clock pulse per period, during the counter-0 tick.
- R8: While `rst_ni` is low, the counter is 0 and all shadow words are 0, so `frame_o` is 1 and all three PWM lines are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, twice the system rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | System-rate enable, high on every second clock |
| duty_i | input | 3x10 | Magnitude word per channel, bits [9:2] compare value, [1:0] half-step dither |
| pwm_o | output | 3 | Center-aligned PWM line per channel |
| frame_o | output | 1 | High during the tick at counter 0 |

## Verification
A new word takes effect only from the period after the next 1-to-0 counter step. The bench therefore writes the words right after one frame rise and measures only from the following rise, which keeps the captured value unambiguous. The PWM lines and the frame flag are decoded from registers that change on the ticked clock edge, so the bench samples them on the falling edge of each clock. It indexes every sample by its clock offset from the frame rise and compares each position with a waveform computed from window bounds. In the middle of each measured period the bench drives the complement of every word, and any effect of that change shows up as a mismatch in the second part of the window.

// File: rtl/tri_pwm_pkg.sv
`timescale 1ns/1ps
package tri_pwm_pkg;
  localparam int unsigned NCH    = 3;
  localparam int unsigned FRAC_W = 2;

  // Half-ticks added after the rising-side edge of the high window.
  function automatic logic [1:0] ext_late(input logic [FRAC_W-1:0] f);
    logic [FRAC_W:0] s;
    s = {1'b0, f} + 3'd1;
    return s[FRAC_W:1];
  endfunction

  // Half-ticks added before the falling-side edge of the high window.
  function automatic logic [1:0] ext_early(input logic [FRAC_W-1:0] f);
    return {1'b0, f[FRAC_W-1]};
  endfunction
endpackage

// File: rtl/tri_pwm_ramp.sv
`timescale 1ns/1ps
module tri_pwm_ramp #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             up_side,
  output logic             half,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] PEAK = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic climbing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      climbing <= 1'b1;
      half     <= 1'b0;
    end else begin
      half <= !tick;
      if (tick) begin
        if (climbing) begin
          cnt <= cnt + ONE;
          if (cnt == PEAK - ONE) climbing <= 1'b0;
        end else begin
          cnt <= cnt - ONE;
          if (cnt == ONE) climbing <= 1'b1;
        end
      end
    end
  end

  // The peak tick counts as part of the rising side.
  assign up_side = climbing || (cnt == PEAK);
  assign wrap    = tick && !climbing && (cnt == ONE);
endmodule

// File: rtl/tri_pwm_lane.sv
`timescale 1ns/1ps
module tri_pwm_lane
  import tri_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned WORD_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] duty,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              up_side,
  input  logic              half,
  output logic [WORD_W-1:0] shadow,
  output logic              pwm
);
  localparam logic [CNT_W-1:0] PEAK = '1;

  logic [CNT_W-1:0]  level;
  logic [FRAC_W-1:0] frac;
  logic [CNT_W:0]    level_p1;
  logic [1:0]        late_n;
  logic [1:0]        early_n;
  logic              in_base;
  logic              at_edge;
  logic              late_hit;
  logic              early_hit;
  logic              peak_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow <= '0;
    else if (load) shadow <= duty;
  end

  assign level    = shadow[WORD_W-1:FRAC_W];
  assign frac     = shadow[FRAC_W-1:0];
  assign level_p1 = {1'b0, level} + (CNT_W+1)'(1);
  assign late_n   = ext_late(frac);
  assign early_n  = ext_early(frac);

  assign in_base   = cnt <= level;
  assign at_edge   = {1'b0, cnt} == level_p1;
  assign late_hit  = at_edge && up_side && (half ? (late_n == 2'd2) : (late_n != 2'd0));
  assign early_hit = at_edge && !up_side && half && (early_n != 2'd0);
  // Level one below the peak: the early share also lands on the peak tick.
  assign peak_hit  = (level == PEAK - CNT_W'(1)) && (cnt == PEAK) && half && (early_n != 2'd0);

  assign pwm = in_base || late_hit || early_hit || peak_hit;
endmodule

// File: rtl/tri_dither_pwm.sv
`timescale 1ns/1ps
module tri_dither_pwm
  import tri_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned WORD_W = CNT_W + FRAC_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [NCH-1:0][WORD_W-1:0] duty_i,
  output logic [NCH-1:0]             pwm_o,
  output logic                       frame_o
);
  logic [CNT_W-1:0]            cnt_w;
  logic                        up_w;
  logic                        half_w;
  logic                        load_w;
  logic [NCH-1:0][WORD_W-1:0]  shadow_w;

  tri_pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .tick    (tick_i),
    .cnt     (cnt_w),
    .up_side (up_w),
    .half    (half_w),
    .wrap    (load_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    tri_pwm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .load    (load_w),
      .duty    (duty_i[g]),
      .cnt     (cnt_w),
      .up_side (up_w),
      .half    (half_w),
      .shadow  (shadow_w[g]),
      .pwm     (pwm_o[g])
    );
  end

  assign frame_o = cnt_w == '0;
endmodule

// File: rtl/tri_dither_pwm_chk.sv
`timescale 1ns/1ps
module tri_dither_pwm_chk
  import tri_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned WORD_W = CNT_W + FRAC_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic [CNT_W-1:0]           cnt,
  input logic                       up_side,
  input logic                       half,
  input logic                       load,
  input logic [NCH-1:0][WORD_W-1:0] shadow,
  input logic [NCH-1:0]             pwm,
  input logic                       frame
);
  localparam logic [CNT_W-1:0] PEAK = '1;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_climb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && up_side && cnt != PEAK |=> cnt == $past(cnt) + CNT_W'(1));
  p_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == PEAK |=> cnt == PEAK - CNT_W'(1));
  p_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> $past(load));
  p_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow));
  p_zero_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 |-> &pwm);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} > {1'b0, shadow[g][WORD_W-1:FRAC_W]} + (CNT_W+1)'(1)) |-> !pwm[g]);
    p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shadow[g][WORD_W-1:FRAC_W] == PEAK |-> pwm[g]);
    p_late_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      up_side && half && shadow[g][FRAC_W-1:0] != 2'd3
      && shadow[g][WORD_W-1:FRAC_W] < PEAK - CNT_W'(1)
      && {1'b0, cnt} == {1'b0, shadow[g][WORD_W-1:FRAC_W]} + (CNT_W+1)'(1) |-> !pwm[g]);
  end
endmodule

bind tri_dither_pwm tri_dither_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .tick    (tick_i),
  .cnt     (cnt_w),
  .up_side (up_w),
  .half    (half_w),
  .load    (load_w),
  .shadow  (shadow_w),
  .pwm     (pwm_o),
  .frame   (frame_o)
);

// File: tb/tb_tri_dither_pwm.sv
`timescale 1ns/1ps
module tb_tri_dither_pwm;
  localparam int PER   = 1020;
  localparam int VEC_N = 13;
  // word, expected high clocks per period
  localparam int VEC [VEC_N][2] = '{
    '{0, 2}, '{1, 3}, '{2, 4}, '{3, 5}, '{400, 402}, '{401, 403},
    '{514, 516}, '{151, 153}, '{1016, 1018}, '{1017, 1019},
    '{1018, 1020}, '{1019, 1020}, '{1023, 1020}};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [2:0][9:0] duty = '0;
  logic [2:0]      pwm;
  logic            frame;

  int nchk = 0;
  int nerr = 0;
  logic prev_f = 1'b0;
  logic cur_f  = 1'b0;

  tri_dither_pwm dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .duty_i  (duty),
    .pwm_o   (pwm),
    .frame_o (frame)
  );

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    prev_f = cur_f;
    cur_f  = frame;
  endtask

  task automatic wait_frame();
    do step(); while (!(cur_f && !prev_f));
  endtask

  // Window model: high before the late bound or from the early bound on.
  function automatic bit exp_hi(input int w, input int p);
    int m, l;
    m = w / 4;
    l = w % 4;
    return (p < 2 * m + 2 + (l + 1) / 2) || (p >= PER - 2 * m - l / 2);
  endfunction

  function automatic string pat_tag(input int w);
    if (w == 0) return "R7";
    if (w / 4 >= 254) return "R5";
    if (w % 4 == 0) return "R3";
    return "R4";
  endfunction

  task automatic run_vec(input int i);
    int w [3];
    int hi [3];
    int bad_a [3];
    int bad_b [3];
    int bad_f;
    for (int c = 0; c < 3; c++) begin
      w[c] = VEC[(i + c) % VEC_N][0];
      hi[c] = 0; bad_a[c] = 0; bad_b[c] = 0;
    end
    bad_f = 0;
    wait_frame();
    for (int c = 0; c < 3; c++) duty[c] = 10'(w[c]);
    wait_frame();
    for (int p = 0; p < PER; p++) begin
      if (p > 0) step();
      for (int c = 0; c < 3; c++) begin
        if (pwm[c]) hi[c]++;
        if (pwm[c] != exp_hi(w[c], p)) begin
          if (p < 300) bad_a[c]++; else bad_b[c]++;
        end
      end
      if (frame != (p < 2)) bad_f++;
      if (p == 300) for (int c = 0; c < 3; c++) duty[c] = ~10'(w[c]);
    end
    step();
    check(cur_f && !prev_f, "R1 period length", int'(cur_f), 1);
    check(bad_f == 0, "R1 frame window", bad_f, 0);
    for (int c = 0; c < 3; c++) begin
      check(hi[c] == VEC[(i + c) % VEC_N][1], "R2 high clocks", hi[c], VEC[(i + c) % VEC_N][1]);
      check(bad_a[c] == 0, pat_tag(w[c]), bad_a[c], 0);
      check(bad_b[c] == 0, "R6 mid-period change", bad_b[c], 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(frame == 1'b1, "R8 frame in reset", int'(frame), 1);
    check(pwm == 3'b111, "R8 pwm in reset", int'(pwm), 7);
    rst_n = 1'b1;
    cur_f = 1'b1;
    prev_f = 1'b1;
    for (int i = 0; i < VEC_N; i++) run_vec(i);
    repeat (137) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(frame == 1'b1, "R8 frame after mid-run reset", int'(frame), 1);
    check(pwm == 3'b111, "R8 pwm after mid-run reset", int'(pwm), 7);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule